// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block turns one 32-bit command word, written by software over a simple register port, into a clause-22 management frame on the MDC clock and MDIO data lines of an Ethernet PHY. The command word already holds the start pattern, the operation code, the PHY address, the register address, the turnaround pattern and, for a write, the 16-bit data. The controller sends a 32-bit preamble of ones and then shifts out all 32 command bits, most significant bit first.

A status register carries an idle flag that software polls before and after each command. For a read, the controller releases MDIO during the turnaround and the data phase. It samples the PHY's reply on rising MDC edges and places the 16 bits back in the low half of the command register. MDC is derived from the system clock by a fixed even divider, 48 by default, which keeps a 120 MHz clock at or below 2.5 MHz. Setting the divider to 64 covers clocks up to 160 MHz. The port does nothing until its enable bit is set.

Top module: `mdio_mgmt`

## Requirements
- R1: Out of reset, MDC is low, MDIO is not driven (output enable 0), the status idle flag (status bit 2) reads 1, and the control and command registers read 0.
- R2: A frame is 64 MDC periods: 32 ones, then command bits 31 down to 0. MDIO output changes only when MDC falls, and each bit is held across one whole MDC period.
- R3: MDC has a period of CLK_DIV system clocks (CLK_DIV even), with its high phase lasting CLK_DIV/2 clocks. MDC stays low whenever no frame is in progress.
- R4: The idle flag reads 0 from the cycle after an accepted command write until the frame ends, and then reads 1 again. A frame of 64 MDC periods keeps it at 0 for exactly 64*CLK_DIV cycles.
- R5: When command bit 29 is set (read), the output driver is released from the bit that carries command bit 16 until the end of the frame. MDIO is sampled on the rising MDC edges of the last 16 bits, first bit received into bit 15. At completion those bits replace command[15:0], and command[31:16] keep their written value.
- R6: When bit 29 is clear (a write, bit 28 set), the driver stays on for all 64 bits and the command register keeps the written word.
- R7: A command write that arrives while a frame is in progress is ignored. The frame on the wire and the command register are unchanged, and no second frame follows.
- R8: While control bit 4 (port enable) is 0, command writes are ignored and MDC stays low.
- R9: Clearing port enable during a frame aborts it. Within two cycles of the control write, MDC is low, the driver is released and idle reads 1.
- R10: The register index selects what is read or written: 0 is control (only bit 4 is held, the other bits read 0), 1 is status (only bit 2), 2 is command, and 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Register index for reads and writes |
| regWrEn | input | 1 | Register write strobe, one cycle |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | MDIO output value |
| mdioOe | output | 1 | MDIO output enable (1 = drive) |
| mdioIn | input | 1 | MDIO value from the pad |

## Verification
The bench uses a small divider and sweeps read frames across all 32 PHY addresses, each paired with its own computed register address and reply pattern. Any bit that is misordered, shifted by one position or sampled at the wrong edge therefore shows up as a mismatch in the captured frame or in the returned data. It also sweeps write frames across all 32 register addresses, so that a write can be told apart from a read by whether the driver stays on and whether the command register is left untouched. A command written mid-frame, a command written while the port is disabled, and an enable cleared mid-frame each test an ignore path or an abort path at the pins and in the registers. Each frame is also timed: the MDC period is measured and the busy window is counted.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS  = 64;
  localparam int PRE_BITS    = 32;
  localparam int CMD_BITS    = 32;
  localparam int DATA_BITS   = 16;
  localparam int IDX_W       = $clog2(FRAME_BITS) + 1;
  localparam int READ_BIT    = 29;
  localparam int EN_BIT      = 4;
  localparam int IDLE_BIT    = 2;
  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_STAT = 2'd1;
  localparam logic [1:0] IDX_CMD  = 2'd2;

  typedef struct packed {
    logic start;
    logic abort;
    logic sample;
    logic advance;
    logic finish;
  } mdioStrobes_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 48
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             portEn,
  input  logic             cmdWrite,
  output mdioStrobes_t     strb,
  output logic             busy,
  output logic             mdc,
  output logic [IDX_W-1:0] bitIdx
);
  localparam int CW = $clog2(CLK_DIV);
  localparam logic [CW-1:0] DIV_LAST = CW'(CLK_DIV - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(CLK_DIV / 2 - 1);
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(FRAME_BITS - 1);

  logic [CW-1:0] divCnt;
  logic atRise, atFall, lastBit;

  assign atRise  = busy && portEn && (divCnt == HALF_LAST);
  assign atFall  = busy && portEn && (divCnt == DIV_LAST);
  assign lastBit = (bitIdx == LAST_BIT);

  always_comb begin
    strb.start   = cmdWrite && portEn && !busy;
    strb.abort   = busy && !portEn;
    strb.sample  = atRise;
    strb.advance = atFall && !lastBit;
    strb.finish  = atFall && lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      mdc    <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (!portEn) begin
      busy   <= 1'b0;
      mdc    <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (strb.start) begin
      busy   <= 1'b1;
      mdc    <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (busy) begin
      divCnt <= atFall ? '0 : divCnt + 1'b1;
      if (atRise) mdc <= 1'b1;
      if (atFall) begin
        mdc <= 1'b0;
        if (lastBit) busy <= 1'b0;
        else bitIdx <= bitIdx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  mdioStrobes_t     strb,
  input  logic [IDX_W-1:0] bitIdx,
  input  logic             busy,
  input  logic [1:0]       regAddr,
  input  logic             regWrEn,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  output logic             portEn,
  output logic             cmdWrite,
  input  logic             mdioIn,
  output logic             mdioOut,
  output logic             mdioOe
);
  localparam logic [IDX_W-1:0] FIRST_CMD = IDX_W'(PRE_BITS);
  localparam logic [IDX_W-1:0] RELEASE_AT = IDX_W'(PRE_BITS + CMD_BITS - DATA_BITS - 1);
  localparam logic [IDX_W-1:0] FIRST_DATA = IDX_W'(PRE_BITS + CMD_BITS - DATA_BITS);

  logic [CMD_BITS-1:0]  cmdReg;
  logic [CMD_BITS-1:0]  shiftReg;
  logic [DATA_BITS-1:0] rdShift;
  logic                 isRead;
  logic [IDX_W-1:0]     nextIdx;

  assign cmdWrite = regWrEn && (regAddr == IDX_CMD);
  assign nextIdx  = bitIdx + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) portEn <= 1'b0;
    else if (regWrEn && regAddr == IDX_CTRL) portEn <= regWrData[EN_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg   <= '0;
      shiftReg <= '0;
      rdShift  <= '0;
      isRead   <= 1'b0;
      mdioOut  <= 1'b1;
      mdioOe   <= 1'b0;
    end else if (strb.start) begin
      cmdReg   <= regWrData;
      shiftReg <= regWrData;
      isRead   <= regWrData[READ_BIT];
      mdioOut  <= 1'b1;
      mdioOe   <= 1'b1;
    end else if (strb.abort) begin
      mdioOut <= 1'b1;
      mdioOe  <= 1'b0;
    end else begin
      if (strb.sample && isRead && bitIdx >= FIRST_DATA)
        rdShift <= {rdShift[DATA_BITS-2:0], mdioIn};
      if (strb.advance) begin
        if (bitIdx >= FIRST_CMD) begin
          shiftReg <= {shiftReg[CMD_BITS-2:0], 1'b0};
          mdioOut  <= shiftReg[CMD_BITS-2];
        end else if (nextIdx == FIRST_CMD) begin
          mdioOut <= shiftReg[CMD_BITS-1];
        end
        if (isRead && nextIdx >= RELEASE_AT) mdioOe <= 1'b0;
      end
      if (strb.finish) begin
        mdioOut <= 1'b1;
        mdioOe  <= 1'b0;
        if (isRead) cmdReg[DATA_BITS-1:0] <= rdShift;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      IDX_CTRL: regRdData[EN_BIT]   = portEn;
      IDX_STAT: regRdData[IDLE_BIT] = !busy;
      IDX_CMD:  regRdData           = cmdReg;
      default:  regRdData           = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 48
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  regAddr,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mdioStrobes_t     strb;
  logic             busy;
  logic             portEn;
  logic             cmdWrite;
  logic [IDX_W-1:0] bitIdx;

  mdio_ctrl #(.CLK_DIV(CLK_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .portEn(portEn), .cmdWrite(cmdWrite),
    .strb(strb), .busy(busy), .mdc(mdc), .bitIdx(bitIdx)
  );

  mdio_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bitIdx(bitIdx), .busy(busy),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .portEn(portEn), .cmdWrite(cmdWrite),
    .mdioIn(mdioIn), .mdioOut(mdioOut), .mdioOe(mdioOe)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       portEn,
  input logic       mdc,
  input logic       mdioOut,
  input logic       mdioOe,
  input logic       regWrEn,
  input logic [1:0] regAddr
);
  p_mdc_low_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);

  p_released_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdioOe);

  p_out_on_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdioOut));

  p_oe_on_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdioOe));

  p_abort_r9: assert property (@(posedge clk) disable iff (!rstN)
    !portEn |=> !busy);

  p_start_on_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(regWrEn) && $past(regAddr) == 2'd2));
endmodule

bind mdio_mgmt mdio_mgmt_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .portEn(portEn), .mdc(mdc),
  .mdioOut(mdioOut), .mdioOe(mdioOe), .regWrEn(regWrEn), .regAddr(regAddr)
);

// File: tb/sim_mdio_mgmt.sv
module sim_mdio_mgmt;
  localparam int DIV = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData;
  logic        mdc, mdioOut, mdioOe;
  logic        phyOe = 1'b0;
  logic        phyBit = 1'b1;
  logic        phyRead = 1'b0;
  logic [15:0] phyData = 16'd0;
  wire         mdioLine = mdioOe ? mdioOut : (phyOe ? phyBit : 1'b1);

  int tests = 0;
  int fails = 0;
  int riseCnt = 0;
  int periodErr = 0;
  int contention = 0;
  int cyc = 0;
  int lastRise = 0;
  logic [63:0] capture = 64'd0;

  mdio_mgmt #(.CLK_DIV(DIV)) u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioLine)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // PHY model: samples on rising MDC, answers reads after falling MDC
  always @(posedge mdc) begin
    if (riseCnt > 0 && (cyc - lastRise) != DIV) periodErr = periodErr + 1;
    lastRise = cyc;
    if (mdioOe && phyOe) contention = contention + 1;
    if (riseCnt < 64) capture[63 - riseCnt] = mdioLine;
    riseCnt = riseCnt + 1;
  end

  always @(negedge mdc) begin
    if (phyRead && riseCnt >= 47 && riseCnt < 64) begin
      phyOe  = 1'b1;
      phyBit = (riseCnt == 47) ? 1'b0 : phyData[63 - riseCnt];
    end else begin
      phyOe  = 1'b0;
      phyBit = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  task automatic modelReset(input bit rd, input logic [15:0] data);
    riseCnt = 0; periodErr = 0; contention = 0; capture = 64'd0;
    phyRead = rd; phyData = data; phyOe = 1'b0; phyBit = 1'b1;
  endtask

  task automatic waitIdle(output int n);
    logic [31:0] s;
    n = 0;
    peek(2'd1, s);
    while (s[2] == 1'b0 && n < 100000) begin
      @(negedge clk);
      n++;
      peek(2'd1, s);
    end
  endtask

  task automatic runFrame(input logic [31:0] cmd, input bit rd, input logic [15:0] data, input string req);
    logic [31:0] s;
    logic [63:0] expFrame;
    int n;
    modelReset(rd, data);
    regWrite(2'd2, cmd);
    peek(2'd1, s);
    check(s[2] == 1'b0, "R4 idle low during frame", {63'd0, s[2]}, 64'd0);
    waitIdle(n);
    check(n == 64 * DIV, "R4 busy window length", 64'(n), 64'(64 * DIV));
    expFrame = rd ? {32'hFFFF_FFFF, cmd[31:17], 1'b0, data} : {32'hFFFF_FFFF, cmd};
    check(capture == expFrame, {req, " R2 frame bits"}, capture, expFrame);
    check(riseCnt == 64, "R2 rising edge count", 64'(riseCnt), 64'd64);
    check(periodErr == 0 && contention == 0, "R3/R5 mdc period and bus contention",
          64'(periodErr + contention), 64'd0);
    peek(2'd2, s);
    if (rd) check(s == {cmd[31:16], data}, "R5 read data in command register", {32'd0, s}, {32'd0, cmd[31:16], data});
    else    check(s == cmd, "R6 write leaves command register", {32'd0, s}, {32'd0, cmd});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] s;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    peek(2'd1, s); check(s == 32'h4, "R1 status after reset", {32'd0, s}, 64'h4);
    peek(2'd0, s); check(s == 32'h0, "R1 control after reset", {32'd0, s}, 64'h0);
    peek(2'd2, s); check(s == 32'h0, "R1 command after reset", {32'd0, s}, 64'h0);
    check(mdc == 1'b0 && mdioOe == 1'b0, "R1 mdc low, driver off", {62'd0, mdc, mdioOe}, 64'd0);

    // R8 disabled port ignores command
    modelReset(1'b0, 16'd0);
    regWrite(2'd2, 32'h5012_0000);
    repeat (100) @(negedge clk);
    check(riseCnt == 0, "R8 no mdc while disabled", 64'(riseCnt), 64'd0);
    peek(2'd2, s); check(s == 32'h0, "R8 command not stored", {32'd0, s}, 64'h0);
    peek(2'd1, s); check(s == 32'h4, "R8 still idle", {32'd0, s}, 64'h4);

    // R10 register map
    regWrite(2'd0, 32'hFFFF_FFFF);
    peek(2'd0, s); check(s == 32'h10, "R10 control holds only enable", {32'd0, s}, 64'h10);
    peek(2'd3, s); check(s == 32'h0, "R10 index 3 reads zero", {32'd0, s}, 64'h0);

    // R5 read sweep over PHY addresses
    for (int p = 0; p < 32; p++) begin
      logic [4:0] ra;
      logic [15:0] d;
      ra = 5'((p * 7) & 31);
      d = 16'(p * 16'h0813) ^ 16'hA5C3;
      runFrame(32'h4002_0000 | (32'd1 << 29) | (32'(p) << 23) | (32'(ra) << 18) | 32'h0000_FFFF,
               1'b1, d, "R5 read");
    end

    // R6 write sweep over register addresses
    for (int r = 0; r < 32; r++) begin
      logic [15:0] d;
      d = 16'(r * 16'h1111) ^ 16'h3C5A;
      runFrame(32'h4002_0000 | (32'd1 << 28) | (32'(31 - r) << 23) | (32'(r) << 18) | 32'(d),
               1'b0, 16'd0, "R6 write");
    end

    // R7 command write during a frame is ignored
    modelReset(1'b1, 16'hBEEF);
    regWrite(2'd2, 32'h6086_0000);
    repeat (100) @(negedge clk);
    regWrite(2'd2, 32'h5FFF_1234);
    waitIdle(n);
    check(capture == {32'hFFFF_FFFF, 16'h6086, 16'hBEEF}, "R7 frame unchanged by late write",
          capture, {32'hFFFF_FFFF, 16'h6086, 16'hBEEF});
    peek(2'd2, s); check(s == 32'h6086_BEEF, "R7 command register keeps first word", {32'd0, s}, 64'h6086_BEEF);
    repeat (100) @(negedge clk);
    check(riseCnt == 64, "R7 no second frame", 64'(riseCnt), 64'd64);

    // R9 abort by clearing enable
    modelReset(1'b0, 16'd0);
    regWrite(2'd2, 32'h5092_AAAA);
    repeat (50) @(negedge clk);
    regWrite(2'd0, 32'h0);
    @(negedge clk);
    peek(2'd1, s);
    check(mdc == 1'b0 && mdioOe == 1'b0 && s[2] == 1'b1, "R9 abort releases bus",
          {61'd0, mdc, mdioOe, s[2]}, 64'd1);
    // recovery after re-enable
    regWrite(2'd0, 32'h10);
    runFrame(32'h5092_5555, 1'b0, 16'd0, "R9 recovery");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule